// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Manager

This block is the protection core of a three-phase gate-drive controller. It takes a digital overcurrent comparator level and a digital undervoltage level. It produces one global shutdown that turns off all six gate drivers, and an active-low, open-drain style fault flag. Both inputs are asynchronous and pass through a register synchroniser first.

An overcurrent level must stay high for a minimum number of consecutive clock samples before it counts as a fault. This rejects noise spikes on the sense path. A qualified fault is latched. The latch releases only after a fixed clear interval, and that interval is counted from the moment the qualified overcurrent level returns low. A persistent overcurrent therefore holds the shutdown for as long as it lasts.

The undervoltage level forces the shutdown for exactly as long as it is present, with no latching. Out of reset the supply is treated as bad until a good sample has travelled through the synchroniser. Filter time, clear time and synchroniser depth are cycle-count parameters. At a 100 MHz clock the defaults of 53 and 6500 cycles give 530 ns and 65 us.

Top module: `ocuv_fault_mgr`

## Requirements
- R1: While reset is asserted, and after release until a low undervoltage sample has passed the synchroniser, gate_off_o is 1 and fault_n_o is 0. A low undervoltage sample taken at clock edge k is visible right after edge k+1 (with SYNC_STAGES = 2).
- R2: If oc_raw_i is sampled high at FILT_CYC consecutive edges, starting at edge k, gate_off_o rises right after edge k+FILT_CYC+2 (with SYNC_STAGES = 2).
- R3: A run of at most FILT_CYC-1 consecutive high overcurrent samples never asserts gate_off_o.
- R4: A single low overcurrent sample restarts qualification, so two sub-threshold runs separated by one low sample do not add up to a fault.
- R5: While a qualified overcurrent stays high, gate_off_o stays 1, however long that lasts.
- R6: If the last high sample of a qualified overcurrent is taken at edge j, and later samples are low, gate_off_o stays 1 through edge j+CLR_CYC+2 and falls right after edge j+CLR_CYC+3.
- R7: An overcurrent that qualifies again during the clear interval restarts the full clear interval from its own last high sample.
- R8: An undervoltage sample of 1 taken at edge k forces gate_off_o to 1 right after edge k+1. The undervoltage path does not latch: gate_off_o follows the synchronised level one edge later.
- R9: fault_n_o is at all times the complement of gate_off_o. 0 on fault_n_o means a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_raw_i | input | 1 | Overcurrent comparator level, asynchronous, 1 = overcurrent |
| uv_raw_i | input | 1 | Undervoltage level, asynchronous, 1 = supply too low |
| gate_off_o | output | 1 | Global shutdown of all gate drivers, 1 = off |
| fault_n_o | output | 1 | Fault flag, active low, open-drain style |

## Verification
The assertions assume that both raw inputs hold steady around the sampling edge. This makes the synchroniser output a clean delayed copy of the input level. The bench changes the inputs only on falling clock edges, so every level is sampled cleanly.

The window assertions on the filter and the clear timer take the synchronised overcurrent level as ground truth. The stimulus mixes directed runs at exactly FILT_CYC-1 and FILT_CYC samples, re-trips inside the clear interval and single-cycle undervoltage dips with random run lengths. The random run lengths straddle both thresholds.

// File: rtl/ocuv_pkg.sv
package ocuv_pkg;

   // Overcurrent latch phases
   typedef enum logic [1:0] {
      TRIP_IDLE   = 2'd0,   // no latched fault
      TRIP_ACTIVE = 2'd1,   // qualified overcurrent present
      TRIP_COOL   = 2'd2    // overcurrent gone, clear interval running
   } trip_state_e;

   // Counter width able to hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/ocuv_sync.sv
module ocuv_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= RST_VAL;
            else         chain_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
            else         chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ocuv_filter.sv
module ocuv_filter #(
   parameter int FILT_CYC = 53
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   output logic qual_o
);

   import ocuv_pkg::*;

   logic qual_q;

   generate
      if (FILT_CYC == 1) begin : g_pass
         // One sample is enough: plain register
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) qual_q <= 1'b0;
            else         qual_q <= level_i;
         end
      end else begin : g_count
         localparam int CW = cnt_width(FILT_CYC - 1);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               run_q  <= '0;
               qual_q <= 1'b0;
            end else if (!level_i) begin
               run_q  <= '0;
               qual_q <= 1'b0;
            end else if (run_q == LAST) begin
               qual_q <= 1'b1;
            end else begin
               run_q  <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign qual_o = qual_q;

endmodule

// File: rtl/ocuv_latch.sv
module ocuv_latch #(
   parameter int CLR_CYC = 6500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic qual_i,
   output logic tripped_o
);

   import ocuv_pkg::*;

   localparam int TW = cnt_width(CLR_CYC - 1);
   localparam logic [TW-1:0] LAST = TW'(CLR_CYC - 1);

   trip_state_e   state_q;
   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= TRIP_IDLE;
         tmr_q   <= '0;
      end else begin
         unique case (state_q)
            TRIP_IDLE: begin
               tmr_q <= '0;
               if (qual_i) state_q <= TRIP_ACTIVE;
            end
            TRIP_ACTIVE: begin
               if (!qual_i) begin
                  // first low sample is the first cycle of the interval
                  if (CLR_CYC == 1) begin
                     state_q <= TRIP_IDLE;
                     tmr_q   <= '0;
                  end else begin
                     state_q <= TRIP_COOL;
                     tmr_q   <= TW'(1);
                  end
               end
            end
            TRIP_COOL: begin
               if (qual_i) begin
                  state_q <= TRIP_ACTIVE;
                  tmr_q   <= '0;
               end else if (tmr_q == LAST) begin
                  state_q <= TRIP_IDLE;
                  tmr_q   <= '0;
               end else begin
                  tmr_q   <= tmr_q + 1'b1;
               end
            end
            default: begin
               state_q <= TRIP_IDLE;
               tmr_q   <= '0;
            end
         endcase
      end
   end

   assign tripped_o = (state_q != TRIP_IDLE);

endmodule

// File: rtl/ocuv_fault_mgr.sv
module ocuv_fault_mgr #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 53,
   parameter int CLR_CYC     = 6500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic oc_raw_i,
   input  logic uv_raw_i,
   output logic gate_off_o,
   output logic fault_n_o
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("FILT_CYC must be at least 1");
      end
      if (CLR_CYC < 1) begin : g_bad_clr
         $error("CLR_CYC must be at least 1");
      end
   endgenerate

   logic oc_sync, uv_sync, oc_filt, oc_tripped, fault_any;

   ocuv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) oc_sync_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (oc_raw_i), .q_o (oc_sync)
   );

   // supply counts as bad until a good sample arrives
   ocuv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uv_sync_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (uv_raw_i), .q_o (uv_sync)
   );

   ocuv_filter #(.FILT_CYC(FILT_CYC)) filt_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .level_i (oc_sync), .qual_o (oc_filt)
   );

   ocuv_latch #(.CLR_CYC(CLR_CYC)) latch_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .qual_i (oc_filt), .tripped_o (oc_tripped)
   );

   assign fault_any  = oc_tripped | uv_sync;
   assign gate_off_o = fault_any;
   assign fault_n_o  = ~fault_any;

endmodule

// File: rtl/ocuv_fault_mgr_chk.sv
module ocuv_fault_mgr_chk #(
   parameter int FILT_CYC = 53,
   parameter int CLR_CYC  = 6500
) (
   input logic clk_i,
   input logic rst_ni,
   input logic oc_s,
   input logic oc_f,
   input logic uv_s,
   input logic tripped,
   input logic gate_off_o,
   input logic fault_n_o
);

   import ocuv_pkg::*;

   localparam int RW = cnt_width(FILT_CYC);
   localparam int LW = cnt_width(CLR_CYC);

   logic [RW-1:0] hi_run_q;
   logic [LW-1:0] lo_run_q;

   // consecutive high synchronised samples, saturating
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       hi_run_q <= '0;
      else if (!oc_s)                    hi_run_q <= '0;
      else if (hi_run_q != RW'(FILT_CYC)) hi_run_q <= hi_run_q + 1'b1;
   end

   // consecutive low qualified samples, saturating
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       lo_run_q <= '0;
      else if (oc_f)                     lo_run_q <= '0;
      else if (lo_run_q != LW'(CLR_CYC)) lo_run_q <= lo_run_q + 1'b1;
   end

   assert_trip_follows_filter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oc_f) |=> (gate_off_o && tripped));

   assert_filter_min_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_f |-> (hi_run_q == RW'(FILT_CYC)));

   assert_held_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oc_f && $past(oc_f)) |-> gate_off_o);

   assert_clear_interval_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tripped) |-> (lo_run_q == LW'(CLR_CYC)));

   assert_uv_forces_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_s |-> (gate_off_o && !fault_n_o));

endmodule

bind ocuv_fault_mgr ocuv_fault_mgr_chk #(.FILT_CYC(FILT_CYC), .CLR_CYC(CLR_CYC)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .oc_s       (oc_sync),
   .oc_f       (oc_filt),
   .uv_s       (uv_sync),
   .tripped    (oc_tripped),
   .gate_off_o (gate_off_o),
   .fault_n_o  (fault_n_o)
);

// File: tb/ocuv_fault_mgr_tb.sv
module ocuv_fault_mgr_tb_top;

   localparam int FILT = 6;
   localparam int CLR  = 40;

   logic clk = 1'b0;
   logic rst_n, oc_in, uv_in;
   logic gate_off, fault_n;

   always #2 clk = ~clk;   // 250 MHz

   ocuv_fault_mgr #(.SYNC_STAGES(2), .FILT_CYC(FILT), .CLR_CYC(CLR)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .oc_raw_i (oc_in), .uv_raw_i (uv_in),
      .gate_off_o (gate_off), .fault_n_o (fault_n)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string tag    = "R1";

   // requirement-level model in the input sample domain
   int         m_run, m_clr;
   logic       m_lat;
   logic [3:0] oc_dl;   // R2/R6: latch state visible three edges later
   logic [1:0] uv_dl;   // R8: undervoltage visible one edge later

   function automatic logic exp_fault();
      return oc_dl[3] | uv_dl[1];
   endfunction

   task automatic model_reset();
      m_run = 0; m_clr = 0; m_lat = 1'b0;
      oc_dl = 4'b0000; uv_dl = 2'b11;
   endtask

   task automatic model_step();
      if (oc_in) m_run = (m_run < FILT) ? m_run + 1 : m_run;
      else       m_run = 0;
      if (m_run >= FILT) begin
         m_lat = 1'b1; m_clr = 0;
      end else if (m_lat) begin
         m_clr++;
         if (m_clr == CLR) begin m_lat = 1'b0; m_clr = 0; end
      end
      oc_dl = {oc_dl[2:0], m_lat};
      uv_dl = {uv_dl[0], uv_in};
   endtask

   task automatic chk(string t, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", t, act, exp, $time);
      end
   endtask

   // one clock: model follows the posedge, outputs checked at negedge
   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
      chk({tag, " gate_off"}, gate_off, exp_fault());
      chk("R9 fault_n", fault_n, ~exp_fault());
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic pulse(int hi, int lo);
      oc_in = 1'b1; run(hi);
      oc_in = 1'b0; run(lo);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; oc_in = 1'b0; uv_in = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset gate_off", gate_off, 1'b1);
      chk("R1 reset fault_n", fault_n, 1'b0);
      rst_n = 1'b1;

      tag = "R1"; run(4);
      chk("R1 uv held", gate_off, 1'b1);
      uv_in = 1'b0; cyc();
      chk("R1 still bad one edge", gate_off, 1'b1);
      cyc();
      chk("R1 supply good", gate_off, 1'b0);
      run(3);

      // R2 exact trip latency, then R6 exact release
      tag = "R2";
      oc_in = 1'b1; run(FILT); oc_in = 1'b0;
      run(2);
      chk("R2 not yet", gate_off, 1'b0);
      cyc();
      chk("R2 tripped", gate_off, 1'b1);
      tag = "R6";
      run(CLR - 1);
      chk("R6 still held", gate_off, 1'b1);
      cyc();
      chk("R6 released", gate_off, 1'b0);
      run(5);

      tag = "R3"; pulse(FILT - 1, FILT + 6);
      chk("R3 short pulse ignored", gate_off, 1'b0);

      tag = "R4";
      oc_in = 1'b1; run(FILT - 1);
      oc_in = 1'b0; cyc();
      oc_in = 1'b1; run(FILT - 1);
      oc_in = 1'b0; run(8);
      chk("R4 split pulse ignored", gate_off, 1'b0);

      tag = "R5";
      oc_in = 1'b1; run(300);
      chk("R5 held overcurrent", gate_off, 1'b1);
      oc_in = 1'b0; run(CLR + 5);
      chk("R5 released after hold", gate_off, 1'b0);

      tag = "R7";
      pulse(FILT, CLR / 2);
      oc_in = 1'b1; run(FILT); oc_in = 1'b0;
      run(CLR + 2);
      chk("R7 interval restarted", gate_off, 1'b1);
      cyc();
      chk("R7 released", gate_off, 1'b0);
      run(4);

      tag = "R8";
      uv_in = 1'b1; cyc(); uv_in = 1'b0;
      chk("R8 not yet", gate_off, 1'b0);
      cyc();
      chk("R8 forced off", gate_off, 1'b1);
      cyc();
      chk("R8 no latch", gate_off, 1'b0);
      run(3);

      tag = "R3 R6 R7 R8 random";
      for (int k = 0; k < 300; k++) begin
         oc_in = 1'b1;
         run(1 + int'($urandom_range(2 * FILT)));
         oc_in = 1'b0;
         if ($urandom_range(9) == 0) uv_in = 1'b1;
         run(1 + int'($urandom_range(CLR + CLR / 2)));
         uv_in = 1'b0;
      end
      run(CLR + 8);
      chk("R6 final idle", gate_off, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule